// File: doc/BRIEF.md
# Serial-Programmed Control Register Bank

This block gives a host processor access to a bank of 128 eight-bit control registers over a four-wire synchronous serial link. The wires are a serial clock, serial data in, serial data out and an active-low select. The link pins are asynchronous to the chip. They pass through a synchroniser into the system clock domain, and all frame decoding runs on detected edges of the synchronised serial clock.

Every access is one 16-bit frame, sent most significant bit first. The first bit is the direction (1 = write, 0 = read), the next seven bits are the register address, and the last eight bits are data. A write stores the data byte in the addressed register when the frame completes. A read ignores the data byte on the input line and instead shifts the addressed register onto the output line, one bit per falling serial-clock edge. The output holds its last bit until the host releases select, and it sits at logic 1 whenever select is released.

Top module: `spi_regfile_target`

## Requirements
- R1: A frame is sampled on rising serial-clock edges, MSB first: bit 15 is the direction (1 = write), bits 14..8 are the address, bits 7..0 are data. A write frame stores the data byte in the addressed register on its 16th rising edge.
- R2: In a read frame, the addressed register is driven on the output MSB first: D7 after the falling edge that follows the 8th rising edge, then one further bit after each following falling edge, D0 last.
- R3: In a read frame the eight data bits on the input line are ignored, and the read leaves every register unchanged.
- R4: After the last bit of a read has been driven, the output keeps the D0 level for as long as select stays low.
- R5: The output is 1 while select is high, during the command byte of every frame, and for the whole of a write frame.
- R6: Releasing select before the 16th rising edge aborts the frame: no register changes, and the next frame decodes from its first bit.
- R7: After reset, every register reads 0x00 and the output is 1.
- R8: Serial-clock edges after the 16th in one selection are ignored until select is released. They cause no second write and no output change.
- R9: A write changes only the addressed register. The other 127 keep their contents across arbitrary mixes of writes and reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the host, asynchronous to clk |
| ser_din | input | 1 | Serial data from the host, sampled on ser_clk rising edges |
| ser_sel_n | input | 1 | Active-low frame select from the host |
| ser_dout | output | 1 | Serial read data to the host, updated after ser_clk falling edges |

## Verification
On every cycle, the assertions check four things. The output changes only after a detected falling serial edge or a released select. It returns to 1 after release and stays high through write frames. A register write happens only inside a selected frame whose captured direction is write, and never after the frame has completed. The bench's scenarios cover the rest: bit order and the value written, read data arriving MSB first, the D0 hold level, that a read ignores its data byte, and that aborted partial writes leave the addressed register untouched. It also covers the independence of all 128 registers, checked against a reference model under random traffic.

// File: rtl/spi_regfile_pkg.sv
// Package: shared pin bundle type and reset levels for the serial register bank.
// Assumes: the pins are sampled as one bundle so that they see equal latency.
package spi_regfile_pkg;

    // Bundle of the three host-driven pins after sampling.
    typedef struct packed {
        logic sel_n;
        logic din;
        logic sck;
    } ser_pins_t;

    // Level each pin is assumed to hold while the block is in reset.
    localparam ser_pins_t PINS_RESET = '{sel_n: 1'b1, din: 1'b0, sck: 1'b0};

endpackage

// File: rtl/spi_pin_sync.sv
// Module: spi_pin_sync
// Brings the asynchronous host pins into the clk domain through a chain of
// STAGES flops. It then flags the rising and falling edges of the synchronised
// serial clock as single-cycle pulses.
// Assumes: each serial clock phase lasts several clk cycles, so no edge is lost.
module spi_pin_sync
    import spi_regfile_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  ser_pins_t pins_async,
    output logic      sck_rise,
    output logic      sck_fall,
    output logic      din_sync,
    output logic      sel_idle
);

    ser_pins_t chain [STAGES];
    logic      sck_prev;

    // Shift the raw pins through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= PINS_RESET;
        end else begin
            chain[0] <= pins_async;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    // Remember the previous synchronised clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= PINS_RESET.sck;
        else        sck_prev <= chain[STAGES-1].sck;
    end

    assign sck_rise = chain[STAGES-1].sck & ~sck_prev;
    assign sck_fall = ~chain[STAGES-1].sck & sck_prev;
    assign din_sync = chain[STAGES-1].din;
    assign sel_idle = chain[STAGES-1].sel_n;

endmodule

// File: rtl/spi_frame_decoder.sv
// Module: spi_frame_decoder
// Counts rising serial edges within a selection, assembles the command byte
// (direction + address) and the data byte, and issues a one-cycle read-load or
// write pulse. A released select clears all frame state at once.
// Assumes: the edge pulses and din come from the same synchroniser stage.
module spi_frame_decoder #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              din_sync,
    input  logic              sel_idle,
    output logic              cmd_valid,
    output logic              cmd_rw,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              rd_load,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              frame_done
);

    localparam int CMD_W   = 1 + ADDR_W;
    localparam int FRAME_W = CMD_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_CMD_LAST   = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] CNT_FRAME_LAST = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] CNT_DONE       = CNT_W'(FRAME_W);

    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-2:0] shreg;

    assign frame_done = (bit_cnt == CNT_DONE);

    // Sample din on rising edges, capture command and data, emit strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || sel_idle) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            cmd_valid <= 1'b0;
            cmd_rw    <= 1'b0;
            cmd_addr  <= '0;
            rd_load   <= 1'b0;
            wr_en     <= 1'b0;
            wr_data   <= '0;
        end else begin
            rd_load <= 1'b0;
            wr_en   <= 1'b0;
            if (sck_rise && !frame_done) begin
                shreg   <= {shreg[FRAME_W-3:0], din_sync};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_CMD_LAST) begin
                    cmd_valid <= 1'b1;
                    cmd_rw    <= shreg[CMD_W-2];
                    cmd_addr  <= {shreg[ADDR_W-2:0], din_sync};
                    rd_load   <= ~shreg[CMD_W-2];
                end
                if (bit_cnt == CNT_FRAME_LAST && cmd_rw) begin
                    wr_en   <= 1'b1;
                    wr_data <= {shreg[DATA_W-2:0], din_sync};
                end
            end
        end
    end

endmodule

// File: rtl/spi_reg_bank.sv
// Module: spi_reg_bank
// Holds 2**ADDR_W registers of DATA_W bits, all cleared by reset.
// One synchronous write port and one combinational read port.
// Assumes: at most one write per cycle; reads see the registered contents.
module spi_reg_bank #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int NREG = 1 << ADDR_W;

    logic [DATA_W-1:0] regs [NREG];

    // Clear all registers on reset, otherwise apply the single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (wr_en) begin
            regs[wr_addr] <= wr_data;
        end
    end

    assign rd_data = regs[rd_addr];

endmodule

// File: rtl/spi_dout_shifter.sv
// Module: spi_dout_shifter
// Loads a register value at the read-load pulse, then presents one bit per
// falling serial edge, MSB first. It holds the last bit until select is
// released, and drives 1 while idle.
// Assumes: the load pulse comes before the first falling edge of the data byte.
module spi_dout_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_idle,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              sck_fall,
    output logic              dout
);

    localparam int REM_W = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] buf_q;
    logic [REM_W-1:0]  remain;

    // Drive out the next bit on each falling edge while bits remain.
    always_ff @(posedge clk) begin
        if (!rst_n || sel_idle) begin
            buf_q  <= '0;
            remain <= '0;
            dout   <= 1'b1;
        end else if (load) begin
            buf_q  <= load_data;
            remain <= REM_W'(DATA_W);
        end else if (sck_fall && remain != '0) begin
            dout   <= buf_q[DATA_W-1];
            buf_q  <= {buf_q[DATA_W-2:0], 1'b0};
            remain <= remain - 1'b1;
        end
    end

endmodule

// File: rtl/spi_regfile_target.sv
// Module: spi_regfile_target (top)
// Serial target giving a host read/write access to a bank of control registers.
// Frame: direction bit (1 = write), address, data, MSB first.
// Assumes: the serial clock is much slower than clk (each phase several cycles).
module spi_regfile_target
    import spi_regfile_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_din,
    input  logic ser_sel_n,
    output logic ser_dout
);

    ser_pins_t         pins_async;
    logic              sck_rise;
    logic              sck_fall;
    logic              din_sync;
    logic              sel_idle;
    logic              cmd_valid;
    logic              cmd_rw;
    logic [ADDR_W-1:0] cmd_addr;
    logic              rd_load;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    logic              frame_done;

    assign pins_async = '{sel_n: ser_sel_n, din: ser_din, sck: ser_clk};

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins_async (pins_async),
        .sck_rise   (sck_rise),
        .sck_fall   (sck_fall),
        .din_sync   (din_sync),
        .sel_idle   (sel_idle)
    );

    spi_frame_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_rise   (sck_rise),
        .din_sync   (din_sync),
        .sel_idle   (sel_idle),
        .cmd_valid  (cmd_valid),
        .cmd_rw     (cmd_rw),
        .cmd_addr   (cmd_addr),
        .rd_load    (rd_load),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .frame_done (frame_done)
    );

    spi_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (cmd_addr),
        .wr_data (wr_data),
        .rd_addr (cmd_addr),
        .rd_data (rd_data)
    );

    spi_dout_shifter #(.DATA_W(DATA_W)) u_dout (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_idle  (sel_idle),
        .load      (rd_load),
        .load_data (rd_data),
        .sck_fall  (sck_fall),
        .dout      (ser_dout)
    );

endmodule

// File: rtl/spi_regfile_target_chk.sv
// Module: spi_regfile_target_chk
// Cycle-by-cycle properties of the serial register bank, bound into the top.
// Assumes: it observes the top's internal synchronised and decoded signals.
module spi_regfile_target_chk (
    input logic clk,
    input logic rst_n,
    input logic sel_idle,
    input logic sck_fall,
    input logic dout,
    input logic wr_en,
    input logic cmd_valid,
    input logic cmd_rw,
    input logic frame_done
);

    // R5: a released select drives the output high on the next cycle.
    p_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_idle |=> dout);

    // R5: the output stays high once a write command has been captured.
    p_write_frame_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_rw) |-> dout);

    // R2/R4: the output moves only after a falling serial edge or a release.
    p_dout_moves_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> ($past(sck_fall) || $past(sel_idle)));

    // R1: a write only follows a captured write command.
    p_write_needs_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (cmd_valid && cmd_rw));

    // R6: no write is issued from an edge seen while select was released.
    p_no_write_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !$past(sel_idle));

    // R8: once the frame has completed, no further write follows.
    p_no_write_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && $past(frame_done)) |-> !wr_en);

endmodule

bind spi_regfile_target spi_regfile_target_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_idle   (sel_idle),
    .sck_fall   (sck_fall),
    .dout       (ser_dout),
    .wr_en      (wr_en),
    .cmd_valid  (cmd_valid),
    .cmd_rw     (cmd_rw),
    .frame_done (frame_done)
);

// File: tb/tb_spi_regfile_target.sv
// Bench: directed corner cases plus seeded random traffic against a model.
module tb_spi_regfile_target;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int FRAME_W    = 16;
    localparam int NREG       = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_din = 1'b0;
    logic ser_sel_n = 1'b1;
    logic ser_dout;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [7:0] model [NREG];
    logic [7:0] got;
    bit         cmd_high;
    bit         all_high;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_regfile_target dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .ser_din   (ser_din),
        .ser_sel_n (ser_sel_n),
        .ser_dout  (ser_dout)
    );

    function automatic logic [15:0] make_frame(bit rw, logic [6:0] a, logic [7:0] d);
        return {rw, a, d};
    endfunction

    function automatic logic [7:0] expect_read(logic [6:0] a);
        return model[a];
    endfunction

    task automatic wait_clks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Select, clock nbits of a frame then extra further pulses; stays selected.
    task automatic shift_frame(bit rw, logic [6:0] a, logic [7:0] d, int nbits, int extra);
        logic [15:0] fr = make_frame(rw, a, d);
        got = '0;
        cmd_high = 1'b1;
        all_high = 1'b1;
        ser_sel_n = 1'b0;
        wait_clks(HALF);
        for (int i = 0; i < nbits + extra; i++) begin
            ser_din = (i < FRAME_W) ? fr[FRAME_W-1-i] : 1'b1;
            wait_clks(HALF);
            if (i >= 8 && i < FRAME_W) got = {got[6:0], ser_dout};
            if (i < 8 && ser_dout !== 1'b1) cmd_high = 1'b0;
            if (ser_dout !== 1'b1) all_high = 1'b0;
            ser_clk = 1'b1;
            wait_clks(HALF);
            ser_clk = 1'b0;
        end
        wait_clks(HALF);
    endtask

    task automatic release_sel();
        ser_sel_n = 1'b1;
        ser_din = 1'b0;
        wait_clks(2 * HALF);
    endtask

    task automatic do_write(logic [6:0] a, logic [7:0] d);
        shift_frame(1'b1, a, d, FRAME_W, 0);
        model[a] = d;
        release_sel();
    endtask

    task automatic do_read(logic [6:0] a, logic [7:0] junk, string req);
        shift_frame(1'b0, a, junk, FRAME_W, 0);
        chk(req, got, expect_read(a));
        release_sel();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d0;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(5);

        // R7: reset state
        chk("R7 idle output after reset", {7'b0, ser_dout}, 8'h01);
        do_read(7'd0,   8'h00, "R7 reg0 reset");
        do_read(7'd127, 8'h00, "R7 reg127 reset");
        do_read(7'd64,  8'h00, "R7 reg64 reset");

        // R1/R2: directed writes and readbacks at the address extremes
        do_write(7'd0, 8'hA5);
        do_write(7'd127, 8'h3C);
        do_write(7'd1, 8'h81);
        do_read(7'd0,   8'h00, "R1 R2 reg0 readback");
        do_read(7'd127, 8'h00, "R1 R2 reg127 readback");
        do_read(7'd1,   8'h00, "R2 reg1 msb and lsb set");

        // R5: write frame keeps the output high; release gives 1
        shift_frame(1'b1, 7'd9, 8'h00, FRAME_W, 0);
        model[9] = 8'h00;
        chk("R5 write frame output high", {7'b0, all_high}, 8'h01);
        release_sel();
        chk("R5 idle after release", {7'b0, ser_dout}, 8'h01);

        // R4/R5: D0 hold after a read, command byte high, then release to 1
        do_write(7'd20, 8'h7E);
        shift_frame(1'b0, 7'd20, 8'h00, FRAME_W, 0);
        chk("R2 read 0x7E", got, 8'h7E);
        chk("R5 command byte high", {7'b0, cmd_high}, 8'h01);
        wait_clks(20);
        chk("R4 hold D0=0", {7'b0, ser_dout}, 8'h00);
        release_sel();
        chk("R5 idle after read", {7'b0, ser_dout}, 8'h01);
        do_write(7'd21, 8'h01);
        shift_frame(1'b0, 7'd21, 8'h00, FRAME_W, 0);
        wait_clks(20);
        chk("R4 hold D0=1", {7'b0, ser_dout}, 8'h01);
        release_sel();

        // R3: data byte of a read ignored, register unchanged
        do_write(7'd33, 8'h5A);
        do_read(7'd33, 8'hFF, "R3 read with junk data");
        do_read(7'd33, 8'h00, "R3 register unchanged by read");

        // R6: aborted writes at 12 and 15 bits leave the register alone
        do_write(7'd5, 8'h11);
        shift_frame(1'b1, 7'd5, 8'hEE, 12, 0);
        release_sel();
        do_read(7'd5, 8'h00, "R6 abort after 12 bits");
        shift_frame(1'b1, 7'd5, 8'hEE, 15, 0);
        release_sel();
        do_read(7'd5, 8'h00, "R6 abort after 15 bits");
        do_write(7'd5, 8'h22);
        do_read(7'd5, 8'h00, "R6 full frame after abort");

        // R8: extra clock pulses after a complete frame are ignored
        shift_frame(1'b1, 7'd40, 8'h96, FRAME_W, 8);
        model[40] = 8'h96;
        chk("R8 output high on extra clocks", {7'b0, all_high}, 8'h01);
        release_sel();
        do_read(7'd40, 8'h00, "R8 no second write");
        do_write(7'd41, 8'hC3);
        shift_frame(1'b0, 7'd41, 8'h00, FRAME_W, 0);
        d0 = got;
        for (int i = 0; i < 6; i++) begin
            ser_clk = 1'b1; wait_clks(HALF);
            ser_clk = 1'b0; wait_clks(HALF);
        end
        chk("R8 read value", d0, 8'hC3);
        chk("R8 D0 held through extra clocks", {7'b0, ser_dout}, 8'h01);
        release_sel();

        // R9: random mix of writes and reads against the model
        for (int n = 0; n < 160; n++) begin
            logic [6:0] a = 7'($urandom_range(0, NREG - 1));
            logic [7:0] d = 8'($urandom);
            if ($urandom_range(0, 1) == 1) do_write(a, d);
            else do_read(a, d, "R9 random readback");
        end
        for (int i = 0; i < 8; i++) begin
            do_read(7'(i * 16 + 3), 8'h00, "R9 sweep readback");
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule